// File: doc/BRIEF.md
# MMC Host Interrupt Router

This block gathers the event sources of a card host controller and turns them into a single CPU interrupt line and two DMA request lines, one for receive and one for transmit. Each of the 13 sources has a sticky request bit. Other units of the controller set a request bit with a one-cycle pulse, and software clears it by writing a 1 to that bit. A mask register, also 13 bits wide, blocks individual sources from reaching the CPU line.

When the DMA-mode input is high, the receive-service bit (5) and the transmit-service bit (6) no longer reach the CPU line. They drive the DMA request lines instead. The block also decodes the clock start/stop command. Starting the clock raises a clock-enabled status flag and clears the clock-off request. Stopping it drops the flag, raises the clock-off request and sends a one-cycle abort to the transfer logic.

The register bus has a 2-bit word address. 0 is clock control: bit 0 stops the clock, bit 1 starts it, and reads return 0. 1 is status, where bit 8 is clock enabled. 2 is the mask. 3 is the request register, which takes write-1-to-clear. Request bit meanings: 0 data done, 1 programming done, 2 command end, 3 stop command, 4 clock off, 5 receive service, 6 transmit service, 7 timeout, 8 data error, 9 response error, 10 read stalled, 11 card interrupt, 12 card acknowledge.

Top module: `mmc_irq_router`

## Requirements
- R1: After reset the request register reads 0, the mask reads all ones (0x1FFF), status reads 0, and cpu_irq, dma_rx_req and dma_tx_req are low.
- R2: A high bit on set_pulse sets the matching request bit at the next clock edge, and the bit stays set until it is cleared.
- R3: Writing address 3 clears each request bit written as 1. If a set pulse and a clear hit the same bit in one cycle, the bit ends up set.
- R4: Writing address 2 stores only the low 13 bits of the write data into the mask, and reads of address 2 return them zero-extended.
- R5: cpu_irq is high when some request bit is set and its mask bit is clear. It is registered, so it follows a change of the request or mask register one cycle later.
- R6: While dma_mode is high, request bits 5 and 6 are treated as masked for cpu_irq.
- R7: While dma_mode is high, dma_rx_req follows request bit 5 and dma_tx_req follows request bit 6, with one cycle of register delay. Both are low when dma_mode is low.
- R8: Writing address 0 with bit 1 set sets status bit 8 and clears request bit 4. A set pulse on bit 4 in the same cycle wins.
- R9: Writing address 0 with bit 0 set clears status bit 8, sets request bit 4 and makes xfer_abort high for one cycle. If bits 0 and 1 are both set, the stop wins.
- R10: Reads have no side effects, and address 0 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 13 | Per-source request set pulses |
| dma_mode | input | 1 | DMA mode for the FIFO service bits |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| cpu_irq | output | 1 | Registered CPU interrupt |
| dma_rx_req | output | 1 | Registered receive DMA request |
| dma_tx_req | output | 1 | Registered transmit DMA request |
| clk_enabled | output | 1 | Clock-enabled flag |
| xfer_abort | output | 1 | One-cycle transfer abort |

## Verification
The bench builds the block with its default parameters: 13 sources, a 32-bit data path, receive service at bit 5, transmit service at bit 6 and clock off at bit 4. With a 32-bit path, upper write bits that must be dropped from the mask are within reach. With 13 sources, bit 4 can collide between the clock command and a set pulse. Since bits 5 and 6 are distinct, the bench can tell the two DMA lines apart when one is cleared and the other stays set.

// File: rtl/mmc_irq_pkg.sv
package mmc_irq_pkg;

    localparam int SRC_COUNT  = 13;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 2;
    localparam int CLKOFF_IDX = 4;
    localparam int RXSVC_IDX  = 5;
    localparam int TXSVC_IDX  = 6;
    localparam int CLKEN_POS  = 8;
    localparam int STOP_POS   = 0;
    localparam int START_POS  = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_CLKCMD = 2'd0,
        RA_STATUS = 2'd1,
        RA_MASK   = 2'd2,
        RA_REQ    = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic start;
        logic stop;
    } clk_cmd_t;

    typedef struct packed {
        logic cpu;
        logic rx;
        logic tx;
    } irq_lines_t;

    function automatic clk_cmd_t decode_clk_cmd(input logic [BUS_W-1:0] d);
        clk_cmd_t c;
        c.start = d[START_POS];
        c.stop  = d[STOP_POS];
        return c;
    endfunction

endpackage

// File: rtl/mmc_irq_clkctl.sv
module mmc_irq_clkctl
    import mmc_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_wr,
    input  clk_cmd_t cmd,
    output logic     clk_en_q,
    output logic     abort_q,
    output logic     clkoff_set,
    output logic     clkoff_clr
);
    // Stop takes priority over start when both are requested.
    assign clkoff_set = cmd_wr & cmd.stop;
    assign clkoff_clr = cmd_wr & cmd.start & ~cmd.stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en_q <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            abort_q <= clkoff_set;
            if (clkoff_set)
                clk_en_q <= 1'b0;
            else if (clkoff_clr)
                clk_en_q <= 1'b1;
        end
    end

    p_stop_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.stop) |=> (!clk_en_q && abort_q));

    p_start_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.start && !cmd.stop) |=> clk_en_q);

endmodule

// File: rtl/mmc_irq_reqbank.sv
module mmc_irq_reqbank #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] req_q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                req_q[b] <= 1'b0;
            else if (set_i[b])
                req_q[b] <= 1'b1;   // set beats clear
            else if (clr_i[b])
                req_q[b] <= 1'b0;
        end
    end

    p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));

    p_clear_takes_r3: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((req_q & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/mmc_irq_maskreg.sv
module mmc_irq_maskreg #(
    parameter int N = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '1;
        else if (wr)
            mask_q <= wdata;
    end

    p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
        wr |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/mmc_irq_outstage.sv
module mmc_irq_outstage
    import mmc_irq_pkg::*;
#(
    parameter int N      = 13,
    parameter int RX_BIT = 5,
    parameter int TX_BIT = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask,
    input  logic         dma_mode,
    output irq_lines_t   lines_q
);
    localparam logic [N-1:0] ONE       = {{(N-1){1'b0}}, 1'b1};
    localparam logic [N-1:0] FIFO_BITS = (ONE << RX_BIT) | (ONE << TX_BIT);

    logic [N-1:0] eff_mask;
    irq_lines_t   lines_d;

    always_comb begin
        eff_mask    = dma_mode ? (mask | FIFO_BITS) : mask;
        lines_d.cpu = |(req & ~eff_mask);
        lines_d.rx  = dma_mode & req[RX_BIT];
        lines_d.tx  = dma_mode & req[TX_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst)
            lines_q <= '0;
        else
            lines_q <= lines_d;
    end

    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
        lines_q.cpu |-> $past(|(req & ~mask)));

    p_dma_hides_fifo_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_mode && ((req & ~mask & ~FIFO_BITS) == '0)) |=> !lines_q.cpu);

    p_dma_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !dma_mode |=> (!lines_q.rx && !lines_q.tx));

endmodule

// File: rtl/mmc_irq_router.sv
module mmc_irq_router
    import mmc_irq_pkg::*;
#(
    parameter int NUM_SRC    = SRC_COUNT,
    parameter int DW         = BUS_W,
    parameter int RX_BIT     = RXSVC_IDX,
    parameter int TX_BIT     = TXSVC_IDX,
    parameter int CLKOFF_BIT = CLKOFF_IDX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_pulse,
    input  logic               dma_mode,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    output logic               cpu_irq,
    output logic               dma_rx_req,
    output logic               dma_tx_req,
    output logic               clk_enabled,
    output logic               xfer_abort
);
    localparam logic [NUM_SRC-1:0] CLKOFF_ONEHOT =
        {{(NUM_SRC-1){1'b0}}, 1'b1} << CLKOFF_BIT;

    reg_addr_e          addr;
    logic               wr_clk, wr_mask, wr_req;
    clk_cmd_t           cmd;
    logic               clkoff_set, clkoff_clr;
    logic [NUM_SRC-1:0] set_all, clr_all;
    logic [NUM_SRC-1:0] req_q, mask_q;
    irq_lines_t         lines_q;
    logic               unused_hi;

    assign addr    = reg_addr_e'(reg_addr);
    assign wr_clk  = reg_wr && (addr == RA_CLKCMD);
    assign wr_mask = reg_wr && (addr == RA_MASK);
    assign wr_req  = reg_wr && (addr == RA_REQ);
    assign cmd     = decode_clk_cmd(reg_wdata);
    assign unused_hi = ^reg_wdata[DW-1:NUM_SRC];

    assign set_all = set_pulse | (clkoff_set ? CLKOFF_ONEHOT : '0);
    assign clr_all = (wr_req ? reg_wdata[NUM_SRC-1:0] : '0)
                   | (clkoff_clr ? CLKOFF_ONEHOT : '0);

    mmc_irq_clkctl u_clk (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (wr_clk),
        .cmd        (cmd),
        .clk_en_q   (clk_enabled),
        .abort_q    (xfer_abort),
        .clkoff_set (clkoff_set),
        .clkoff_clr (clkoff_clr)
    );

    mmc_irq_reqbank #(.N(NUM_SRC)) u_req (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_all),
        .clr_i (clr_all),
        .req_q (req_q)
    );

    mmc_irq_maskreg #(.N(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_mask),
        .wdata  (reg_wdata[NUM_SRC-1:0]),
        .mask_q (mask_q)
    );

    mmc_irq_outstage #(.N(NUM_SRC), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) u_out (
        .clk      (clk),
        .rst      (rst),
        .req      (req_q),
        .mask     (mask_q),
        .dma_mode (dma_mode),
        .lines_q  (lines_q)
    );

    assign cpu_irq    = lines_q.cpu;
    assign dma_rx_req = lines_q.rx;
    assign dma_tx_req = lines_q.tx;

    always_comb begin
        reg_rdata = '0;
        case (addr)
            RA_CLKCMD: reg_rdata = '0;
            RA_STATUS: reg_rdata[CLKEN_POS] = clk_enabled;
            RA_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
            RA_REQ:    reg_rdata[NUM_SRC-1:0] = req_q;
            default:   reg_rdata = '0;
        endcase
    end

    p_stop_sets_clkoff_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> req_q[CLKOFF_BIT]);

    p_dma_rx_source_r7: assert property (@(posedge clk) disable iff (rst)
        dma_rx_req |-> $past(dma_mode && req_q[RX_BIT]));

endmodule

// File: tb/mmc_irq_router_tb_top.sv
module mmc_irq_router_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [12:0] set_pulse;
    logic        dma_mode;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cpu_irq, dma_rx_req, dma_tx_req, clk_enabled, xfer_abort;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    mmc_irq_router dut_i (
        .clk(clk), .rst(rst), .set_pulse(set_pulse), .dma_mode(dma_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_irq(cpu_irq), .dma_rx_req(dma_rx_req),
        .dma_tx_req(dma_tx_req), .clk_enabled(clk_enabled), .xfer_abort(xfer_abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [12:0] b);
        @(negedge clk);
        set_pulse = b;
        @(negedge clk);
        set_pulse = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(2'd3, d); chk("R1 request", d, 32'h0);
        bus_rd(2'd2, d); chk("R1 mask", d, 32'h1FFF);
        bus_rd(2'd1, d); chk("R1 status", d, 32'h0);
        chk("R1 lines", {29'b0, cpu_irq, dma_rx_req, dma_tx_req}, 32'h0);
    endtask

    task automatic t_set_hold;
        logic [31:0] d;
        pulse(13'h0001);
        bus_rd(2'd3, d); chk("R2 set", d, 32'h1);
        @(negedge clk);
        bus_rd(2'd3, d); chk("R2 held", d, 32'h1);
        chk("R5 all masked", {31'b0, cpu_irq}, 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] d;
        bus_wr(2'd2, 32'hFFFF_FFFE);
        bus_rd(2'd2, d); chk("R4 mask low bits", d, 32'h1FFE);
        chk("R5 latency", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        chk("R5 irq raised", {31'b0, cpu_irq}, 32'h1);
    endtask

    task automatic t_clear_race;
        logic [31:0] d;
        bus_wr(2'd3, 32'h1);
        bus_rd(2'd3, d); chk("R3 w1c", d, 32'h0);
        @(negedge clk);
        chk("R5 irq dropped", {31'b0, cpu_irq}, 32'h0);
        @(negedge clk);
        set_pulse = 13'h0004; reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'h4;
        @(negedge clk);
        set_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        bus_rd(2'd3, d); chk("R3 set wins", d, 32'h4);
        bus_wr(2'd3, 32'h4);
        bus_rd(2'd3, d); chk("R3 cleared", d, 32'h0);
    endtask

    task automatic t_dma;
        bus_wr(2'd2, 32'h0);
        @(negedge clk); dma_mode = 1'b1;
        pulse(13'h0060);
        @(negedge clk);
        chk("R6 fifo hidden", {31'b0, cpu_irq}, 32'h0);
        chk("R7 both req", {30'b0, dma_rx_req, dma_tx_req}, 32'h3);
        bus_wr(2'd3, 32'h20);
        @(negedge clk);
        chk("R7 rx only cleared", {30'b0, dma_rx_req, dma_tx_req}, 32'h1);
        dma_mode = 1'b0;
        @(negedge clk);
        chk("R6 fifo to cpu", {31'b0, cpu_irq}, 32'h1);
        chk("R7 dma off", {30'b0, dma_rx_req, dma_tx_req}, 32'h0);
        bus_wr(2'd3, 32'h1FFF);
    endtask

    task automatic t_clock;
        logic [31:0] d;
        pulse(13'h0010);
        bus_wr(2'd0, 32'h2);
        bus_rd(2'd1, d); chk("R8 clk enabled", d, 32'h100);
        bus_rd(2'd3, d); chk("R8 clkoff cleared", d, 32'h0);
        bus_wr(2'd0, 32'h1);
        chk("R9 abort pulse", {31'b0, xfer_abort}, 32'h1);
        bus_rd(2'd1, d); chk("R9 clk disabled", d, 32'h0);
        bus_rd(2'd3, d); chk("R9 clkoff set", d, 32'h10);
        @(negedge clk);
        chk("R9 abort one cycle", {31'b0, xfer_abort}, 32'h0);
        chk("R5 clkoff irq", {31'b0, cpu_irq}, 32'h1);
        bus_wr(2'd0, 32'h2);
        bus_wr(2'd0, 32'h3);
        bus_rd(2'd1, d); chk("R9 stop beats start", d, 32'h0);
        bus_rd(2'd3, d); chk("R9 clkoff on both", d, 32'h10);
        bus_wr(2'd3, 32'h10);
        @(negedge clk);
        set_pulse = 13'h0010; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h2;
        @(negedge clk);
        set_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
        bus_rd(2'd3, d); chk("R8 pulse beats start", d, 32'h10);
        bus_rd(2'd1, d); chk("R8 clk on", d, 32'h100);
    endtask

    task automatic t_reads;
        logic [31:0] d;
        bus_rd(2'd0, d); chk("R10 ctrl reads 0", d, 32'h0);
        bus_rd(2'd3, d);
        @(negedge clk);
        bus_rd(2'd3, d); chk("R10 read no side effect", d, 32'h10);
        bus_rd(2'd1, d); chk("R10 status stable", d, 32'h100);
    endtask

    initial begin
        rst = 1'b1; set_pulse = '0; dma_mode = 1'b0;
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_hold();
        t_mask_irq();
        t_clear_race();
        t_dma();
        t_clock();
        t_reads();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule